// File: doc/BRIEF.md
# Value-or-Tag Rename Register File

This block is the speculative register map of a core that executes out of order in the Tomasulo style. Each architectural register entry is in one of two modes. In value mode it holds a finished data word. In tag mode it holds the tag of the in-flight instruction that will produce that register's next value. Decode reads two source registers each cycle and receives, for each one, either a value or a tag. In the same cycle decode may rename one destination register to a fresh tag.

A result broadcast port carries a tag and its data word. Every entry that is still waiting on that tag changes to value mode and takes the data. A result broadcast in a cycle is also forwarded straight to that cycle's source reads. On an exception, a recovery strobe reloads every entry from the committed architectural values, which are presented as one flat vector, and leaves all entries in value mode.

Every port is a single-cycle strobe or a combinational read. The block accepts every request in the cycle it is presented and never applies back-pressure, so no port has a ready signal. Tag allocation and the architectural file are outside the block.

Top module: `rename_regfile`

## Requirements
- R1: After reset every entry is in value mode holding zero, so both source reads return is_tag=0 and data=0 for any address.
- R2: A destination write (dst_valid=1, dst_addr=r, r nonzero, recover=0) puts entry r in tag mode. From the next cycle, reads of r return is_tag=1 with the tag zero-extended in the data bits.
- R3: A broadcast (cdb_valid=1) whose tag equals the tag held by an entry in tag mode puts that entry in value mode with cdb_data from the next cycle.
- R4: A source read of an entry in tag mode whose tag equals the broadcast tag of the same cycle returns is_tag=0 and cdb_data in that same cycle.
- R5: A broadcast leaves unchanged any entry in value mode, including one whose low data bits equal the broadcast tag, and any entry holding a different tag.
- R6: When a destination write and a broadcast matching that entry's old tag happen in the same cycle, the entry ends up in tag mode with the new tag.
- R7: One broadcast updates every entry that holds its tag, not only the first one.
- R8: Register 0 always reads as value zero. Destination writes to it are ignored.
- R9: recover=1 puts every entry in value mode with its slice of arch_values (entry r takes bits r*DATA_W and up) from the next cycle, and entry 0 stays zero. Recovery takes priority over a destination write and a broadcast in the same cycle.
- R10: A source read in the same cycle as a destination write to that register returns the mapping that was held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_addr | input | ADDR_W | First source register index |
| src_a_is_tag | output | 1 | First source returns a tag (1) or a value (0) |
| src_a_data | output | DATA_W | First source value, or tag zero-extended |
| src_b_addr | input | ADDR_W | Second source register index |
| src_b_is_tag | output | 1 | Second source returns a tag (1) or a value (0) |
| src_b_data | output | DATA_W | Second source value, or tag zero-extended |
| dst_valid | input | 1 | Rename the destination this cycle |
| dst_addr | input | ADDR_W | Destination register index |
| dst_tag | input | TAG_W | New tag for the destination |
| cdb_valid | input | 1 | Result broadcast strobe |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| recover | input | 1 | Reload all entries from committed state |
| arch_values | input | NUM_REGS*DATA_W | Committed values, entry r in slice r |

## Verification
The checker watches every entry on every cycle. It confirms that a rename lands with its tag even when a broadcast matches the old tag, and that a matching broadcast turns a waiting entry into a value. It also confirms that recovery leaves no entry in tag mode and loads the committed slices, that entry 0 never enters tag mode, and that a read forwards the broadcast data when the selected entry waits on the broadcast tag. Only the bench scenarios show the behaviour across whole sequences: several entries sharing one tag, repeated broadcasts that must not disturb entries already in value mode, reads of an entry during its own rename, and the full-map contents after recovery from a mixed state. The bench checks each of these by reading every register through both source ports.

// File: rtl/rrf_pkg.sv
`timescale 1ns/1ps
package rrf_pkg;
  typedef enum logic {
    MODE_VALUE = 1'b0,
    MODE_TAG   = 1'b1
  } rrf_mode_e;
endpackage

// File: rtl/rrf_entry.sv
`timescale 1ns/1ps
module rrf_entry
  import rrf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              rec_en,
  input  logic [DATA_W-1:0] rec_data,
  output logic              is_tag,
  output logic [DATA_W-1:0] payload,
  output logic              bc_hit
);
  rrf_mode_e         mode_q;
  logic [DATA_W-1:0] word_q;

  // an entry resolves only while it still waits on exactly this tag
  assign bc_hit  = bc_valid && (mode_q == MODE_TAG) && (word_q[TAG_W-1:0] == bc_tag);
  assign is_tag  = (mode_q == MODE_TAG);
  assign payload = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_VALUE;
      word_q <= '0;
    end else if (rec_en) begin
      mode_q <= MODE_VALUE;
      word_q <= rec_data;
    end else if (wr_en) begin
      mode_q <= MODE_TAG;
      word_q <= DATA_W'(wr_tag);
    end else if (bc_hit) begin
      mode_q <= MODE_VALUE;
      word_q <= bc_data;
    end
  end
endmodule

// File: rtl/rrf_read_port.sv
`timescale 1ns/1ps
module rrf_read_port #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_REGS-1:0]              ent_is_tag,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  ent_payload,
  input  logic [NUM_REGS-1:0]              ent_hit,
  input  logic [DATA_W-1:0]                bc_data,
  output logic                             is_tag,
  output logic [DATA_W-1:0]                data
);
  logic in_range;
  assign in_range = ({1'b0, addr} < (ADDR_W+1)'(NUM_REGS));

  always_comb begin
    is_tag = 1'b0;
    data   = '0;
    if (in_range) begin
      if (ent_hit[addr]) begin
        is_tag = 1'b0;
        data   = bc_data;
      end else begin
        is_tag = ent_is_tag[addr];
        data   = ent_payload[addr];
      end
    end
  end
endmodule

// File: rtl/rename_regfile.sv
`timescale 1ns/1ps
module rename_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int ADDR_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            src_a_addr,
  output logic                         src_a_is_tag,
  output logic [DATA_W-1:0]            src_a_data,
  input  logic [ADDR_W-1:0]            src_b_addr,
  output logic                         src_b_is_tag,
  output logic [DATA_W-1:0]            src_b_data,
  input  logic                         dst_valid,
  input  logic [ADDR_W-1:0]            dst_addr,
  input  logic [TAG_W-1:0]             dst_tag,
  input  logic                         cdb_valid,
  input  logic [TAG_W-1:0]             cdb_tag,
  input  logic [DATA_W-1:0]            cdb_data,
  input  logic                         recover,
  input  logic [NUM_REGS*DATA_W-1:0]   arch_values
);
  logic [NUM_REGS-1:0]             ent_is_tag;
  logic [NUM_REGS-1:0][DATA_W-1:0] ent_payload;
  logic [NUM_REGS-1:0]             ent_hit;

  // entry 0 is hard-wired to value zero; its committed slice is dropped
  assign ent_is_tag[0]  = 1'b0;
  assign ent_payload[0] = '0;
  assign ent_hit[0]     = 1'b0;
  logic unused_arch0;
  assign unused_arch0 = ^arch_values[DATA_W-1:0];

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_ent
    logic wr_sel;
    assign wr_sel = dst_valid && (dst_addr == ADDR_W'(gi));
    rrf_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) ent_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_sel),
      .wr_tag   (dst_tag),
      .bc_valid (cdb_valid),
      .bc_tag   (cdb_tag),
      .bc_data  (cdb_data),
      .rec_en   (recover),
      .rec_data (arch_values[gi*DATA_W +: DATA_W]),
      .is_tag   (ent_is_tag[gi]),
      .payload  (ent_payload[gi]),
      .bc_hit   (ent_hit[gi])
    );
  end

  rrf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_a_i (
    .addr        (src_a_addr),
    .ent_is_tag  (ent_is_tag),
    .ent_payload (ent_payload),
    .ent_hit     (ent_hit),
    .bc_data     (cdb_data),
    .is_tag      (src_a_is_tag),
    .data        (src_a_data)
  );

  rrf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) rd_b_i (
    .addr        (src_b_addr),
    .ent_is_tag  (ent_is_tag),
    .ent_payload (ent_payload),
    .ent_hit     (ent_hit),
    .bc_data     (cdb_data),
    .is_tag      (src_b_is_tag),
    .data        (src_b_data)
  );
endmodule

// File: rtl/rrf_checker.sv
`timescale 1ns/1ps
module rrf_checker #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  parameter int ADDR_W   = 3
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               src_a_addr,
  input logic                            src_a_is_tag,
  input logic [DATA_W-1:0]               src_a_data,
  input logic                            dst_valid,
  input logic [ADDR_W-1:0]               dst_addr,
  input logic [TAG_W-1:0]                dst_tag,
  input logic                            cdb_valid,
  input logic [TAG_W-1:0]                cdb_tag,
  input logic [DATA_W-1:0]               cdb_data,
  input logic                            recover,
  input logic [NUM_REGS*DATA_W-1:0]      arch_values,
  input logic [NUM_REGS-1:0]             ent_is_tag,
  input logic [NUM_REGS-1:0][DATA_W-1:0] ent_payload
);
  assert_zero_never_tagged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_is_tag[0]);

  assert_read_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && src_a_addr != '0 && ({1'b0, src_a_addr} < (ADDR_W+1)'(NUM_REGS)) &&
     ent_is_tag[src_a_addr] && ent_payload[src_a_addr][TAG_W-1:0] == cdb_tag)
    |-> (!src_a_is_tag && src_a_data == cdb_data));

  for (genvar gi = 1; gi < NUM_REGS; gi++) begin : g_chk
    assert_rename_lands_R2_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dst_valid && dst_addr == ADDR_W'(gi) && !recover)
      |=> (ent_is_tag[gi] && ent_payload[gi][TAG_W-1:0] == $past(dst_tag)));

    assert_broadcast_resolves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && ent_is_tag[gi] && ent_payload[gi][TAG_W-1:0] == cdb_tag && !recover &&
       !(dst_valid && dst_addr == ADDR_W'(gi)))
      |=> (!ent_is_tag[gi] && ent_payload[gi] == $past(cdb_data)));

    assert_recover_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      recover |=> (!ent_is_tag[gi] && ent_payload[gi] == $past(arch_values[gi*DATA_W +: DATA_W])));
  end
endmodule

bind rename_regfile rrf_checker #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .src_a_addr   (src_a_addr),
  .src_a_is_tag (src_a_is_tag),
  .src_a_data   (src_a_data),
  .dst_valid    (dst_valid),
  .dst_addr     (dst_addr),
  .dst_tag      (dst_tag),
  .cdb_valid    (cdb_valid),
  .cdb_tag      (cdb_tag),
  .cdb_data     (cdb_data),
  .recover      (recover),
  .arch_values  (arch_values),
  .ent_is_tag   (ent_is_tag),
  .ent_payload  (ent_payload)
);

// File: tb/rename_regfile_tb_top.sv
`timescale 1ns/1ps
module rename_regfile_tb_top;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int TW = 4;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] src_a_addr = '0, src_b_addr = '0, dst_addr = '0;
  logic          src_a_is_tag, src_b_is_tag;
  logic [DW-1:0] src_a_data, src_b_data;
  logic          dst_valid = 1'b0, cdb_valid = 1'b0, recover = 1'b0;
  logic [TW-1:0] dst_tag = '0, cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic [NR*DW-1:0] arch_values = '0;

  int checks = 0;
  int failures = 0;
  bit mdl_tag [NR];
  logic [DW-1:0] mdl_pay [NR];

  always #5 clk = ~clk;

  rename_regfile #(.NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_a_addr(src_a_addr), .src_a_is_tag(src_a_is_tag), .src_a_data(src_a_data),
    .src_b_addr(src_b_addr), .src_b_is_tag(src_b_is_tag), .src_b_data(src_b_data),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_tag(dst_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .recover(recover), .arch_values(arch_values)
  );

  task automatic expect_read(input int r, output bit e_tag, output logic [DW-1:0] e_dat);
    if (r == 0) begin
      e_tag = 1'b0; e_dat = '0;
    end else if (mdl_tag[r] && cdb_valid && mdl_pay[r][TW-1:0] == cdb_tag) begin
      e_tag = 1'b0; e_dat = cdb_data;
    end else begin
      e_tag = mdl_tag[r]; e_dat = mdl_pay[r];
    end
  endtask

  task automatic check_port(input string req, input string port, input int r,
                            input bit a_tag, input logic [DW-1:0] a_dat);
    bit e_tag;
    logic [DW-1:0] e_dat;
    expect_read(r, e_tag, e_dat);
    checks++;
    if (a_tag !== e_tag || a_dat !== e_dat) begin
      failures++;
      $display("FAIL %s port %s reg %0d: actual tag=%0b data=%h expected tag=%0b data=%h",
               req, port, r, a_tag, a_dat, e_tag, e_dat);
    end
  endtask

  task automatic model_update();
    for (int r = 0; r < NR; r++) begin
      if (recover) begin
        mdl_tag[r] = 1'b0;
        mdl_pay[r] = (r == 0) ? '0 : arch_values[r*DW +: DW];
      end else if (dst_valid && dst_addr == AW'(r) && r != 0) begin
        mdl_tag[r] = 1'b1;
        mdl_pay[r] = DW'(dst_tag);
      end else if (mdl_tag[r] && cdb_valid && mdl_pay[r][TW-1:0] == cdb_tag) begin
        mdl_tag[r] = 1'b0;
        mdl_pay[r] = cdb_data;
      end
    end
  endtask

  // drive one cycle's controls, read every register on both ports, then clock
  task automatic run_cycle(input string req, input bit dv, input int da, input int dt,
                           input bit cv, input int ct, input logic [DW-1:0] cd, input bit rec);
    @(negedge clk);
    dst_valid = dv; dst_addr = AW'(da); dst_tag = TW'(dt);
    cdb_valid = cv; cdb_tag = TW'(ct); cdb_data = cd;
    recover = rec;
    for (int r = 0; r < NR; r++) begin
      src_a_addr = AW'(r);
      src_b_addr = AW'(NR - 1 - r);
      #0.5;
      check_port(req, "a", r, src_a_is_tag, src_a_data);
      check_port(req, "b", NR - 1 - r, src_b_is_tag, src_b_data);
    end
    @(posedge clk);
    model_update();
  endtask

  task automatic idle(input string req);
    run_cycle(req, 1'b0, 0, 0, 1'b0, 0, '0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual run still going, expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++) begin mdl_tag[r] = 1'b0; mdl_pay[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    idle("R1");

    // rename every register, duplicate tags across entries; reg 0 ignored
    for (int r = 0; r < NR; r++) run_cycle("R2 R8 R10", 1'b1, r, r % 4, 1'b0, 0, '0, 1'b0);
    idle("R2 R8");

    // broadcast every tag; same-cycle reads exercise the bypass
    for (int t = 0; t < 16; t++)
      run_cycle("R3 R4 R7", 1'b0, 0, 0, 1'b1, t, 16'(16'hA000 + t * 17), 1'b0);
    idle("R3 R7");

    // all entries in value mode now; low bits of values match some tags
    for (int t = 0; t < 16; t++)
      run_cycle("R5", 1'b0, 0, 0, 1'b1, t, 16'(16'h5000 + t), 1'b0);

    // two tag groups, then rename while the old tag is broadcast
    for (int r = 1; r < NR; r++) run_cycle("R2", 1'b1, r, 8 + (r % 2), 1'b0, 0, '0, 1'b0);
    for (int r = 1; r < NR; r++)
      run_cycle("R6 R10", 1'b1, r, r, 1'b1, 8 + (r % 2), 16'(16'hC000 + r), 1'b0);
    for (int t = 1; t < NR; t++)
      run_cycle("R3 R5", 1'b0, 0, 0, 1'b1, t, 16'(16'h7700 + t), 1'b0);
    idle("R3 R6");

    // recovery from a mixed state, contending with rename and broadcast
    for (int r = 1; r < NR; r += 2) run_cycle("R2", 1'b1, r, r + 3, 1'b0, 0, '0, 1'b0);
    for (int r = 0; r < NR; r++) arch_values[r*DW +: DW] = 16'(r * 16'h1111) ^ 16'h0F0F;
    run_cycle("R9", 1'b1, 3, 12, 1'b1, 4, 16'hDEAD, 1'b1);
    idle("R9");
    for (int r = 2; r < NR; r += 2) run_cycle("R2", 1'b1, r, r, 1'b0, 0, '0, 1'b0);
    for (int r = 0; r < NR; r++) arch_values[r*DW +: DW] = 16'(16'hB000 + r * 3);
    run_cycle("R9", 1'b0, 0, 0, 1'b0, 0, '0, 1'b1);
    idle("R9 R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule